// File: doc/BRIEF.md
# Radix-Tree Page Table Walker

This block resolves a virtual-to-physical translation after a translation cache lookup has missed. It accepts a miss request made of a 48-bit virtual address and the physical base of the top-level table for the current address space. It then descends a four-level radix tree, reading one 8-byte entry per level through a single-outstanding request/response memory port. The walk ends with either a physical address or a fault.

The walker serves one request at a time. While a walk is in flight it raises `busy` and ignores new requests. Each level takes 9 bits of the virtual address as its table index. A level-0 index comes from the top bits of the address, and each later level takes the next 9 bits down. The entry found at the bottom level names a 4 KB frame. The 12-bit page offset is carried through untouched. Loading a different root base on the next request switches the walk to a different tree.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `busy`, `done`, `fault` and `mem_req_valid` are low and `paddr` is zero.
- R2: A request (`req_valid` high) is accepted only while `busy` is low. `req_valid`, `req_vaddr` and `root_base` have no effect while a walk is in progress.
- R3: The first read of a walk goes to `{root_base[51:12], 12'b0} + req_vaddr[47:39]*8`. The low 12 bits of `root_base` are ignored.
- R4: Each later read goes to `{E[51:12], 12'b0} + idx*8`, where E is the entry returned by the level above. The index idx is `vaddr[38:30]`, then `vaddr[29:21]`, then `vaddr[20:12]`. Entry bits 63:52 and 11:1 are ignored.
- R5: `mem_req_valid` is a one-cycle pulse. No new read is issued before the previous one has its `mem_rsp_valid`. A walk that completes without a fault issues exactly four reads.
- R6: An entry with bit 0 (present) clear ends the walk. `fault` pulses for one cycle in the cycle after that response. No further read is issued, so a fault at level L (0..3) costs L+1 reads, and `paddr` keeps its previous value.
- R7: When the fourth entry has bit 0 set, `done` pulses for one cycle in the cycle after that response. From that cycle on, `paddr` equals `{E[51:12], vaddr[11:0]}`.
- R8: `busy` is high from the cycle after acceptance up to the cycle before `done` or `fault`. It is low in the cycle in which `done` or `fault` is high.
- R9: The root base is sampled at acceptance. The same virtual address walked under two different root bases resolves through two different trees.
- R10: `done` and `fault` are never high together, and each walk ends with exactly one such pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Miss request strobe |
| req_vaddr | input | 48 | Virtual address to translate |
| root_base | input | 52 | Physical base of the top-level table (bits 51:12 used) |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Memory read strobe, one cycle |
| mem_req_addr | output | 52 | Physical byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry read from memory |
| done | output | 1 | Walk finished with a translation, one-cycle pulse |
| fault | output | 1 | Walk ended on a non-present entry, one-cycle pulse |
| paddr | output | 52 | Physical address of the last successful walk |

## Verification
A wrong level counter or a wrong latched table base shows up in `mem_req_addr` in the very next issue cycle. The reference model predicts that address every cycle, so such an error is flagged at the first divergent read. A state register that slips shows as a `mem_req_valid` pulse in the wrong cycle, as an extra or missing read, or as `busy` or `done` one cycle off. A walker stuck in its wait state shows as `busy` never dropping, and the per-walk timeout catches that within a few hundred cycles.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } walk_state_e;
endpackage

// File: rtl/ptw_rst_sync.sv
module ptw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/ptw_index_sel.sv
module ptw_index_sel #(
  parameter int VA_W   = 48,
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int LVL_W  = 2
) (
  input  logic [VA_W-1:0]  vaddr,
  input  logic [LVL_W-1:0] level,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] slice [LEVELS];

  // level 0 takes the highest index field, the last level the lowest
  for (genvar g = 0; g < LEVELS; g++) begin : g_slice
    localparam int LSB = OFF_W + IDX_W * (LEVELS - 1 - g);
    assign slice[g] = vaddr[LSB +: IDX_W];
  end

  assign idx = slice[level];
endmodule

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
  parameter int PA_W         = 52,
  parameter int OFF_W        = 12,
  parameter int IDX_W        = 9,
  parameter int PTE_BYTES_LG = 3
) (
  input  logic [PA_W-OFF_W-1:0] base,
  input  logic [IDX_W-1:0]      idx,
  output logic [PA_W-1:0]       addr
);
  logic [OFF_W-1:0] byte_off;

  // a table fills exactly one page, so the scaled index never carries
  assign byte_off = OFF_W'({idx, {PTE_BYTES_LG{1'b0}}});
  assign addr     = {base, byte_off};
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int VA_W         = 48,
  parameter int PA_W         = 52,
  parameter int PTE_W        = 64,
  parameter int LEVELS       = 4,
  parameter int IDX_W        = 9,
  parameter int OFF_W        = 12,
  parameter int PTE_BYTES_LG = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [PA_W-1:0]  root_base,
  output logic             busy,
  output logic             mem_req_valid,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             done,
  output logic             fault,
  output logic [PA_W-1:0]  paddr
);
  import ptw_pkg::*;

  localparam int BASE_W = PA_W - OFF_W;
  localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

  logic rst_n_s;

  walk_state_e       state_q, state_d;
  logic [LVL_W-1:0]  lvl_q, lvl_d;
  logic [VA_W-1:0]   va_q;
  logic [BASE_W-1:0] base_q, base_d;
  logic [PA_W-1:0]   pa_q, pa_d;
  logic              done_q, done_d;
  logic              fault_q, fault_d;
  logic              va_en, base_en, lvl_en, pa_en;
  logic [IDX_W-1:0]  cur_idx;
  logic              rsp_unused;

  ptw_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  ptw_index_sel #(
    .VA_W(VA_W), .LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W), .LVL_W(LVL_W)
  ) u_idx (
    .vaddr (va_q),
    .level (lvl_q),
    .idx   (cur_idx)
  );

  ptw_entry_addr #(
    .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .PTE_BYTES_LG(PTE_BYTES_LG)
  ) u_addr (
    .base (base_q),
    .idx  (cur_idx),
    .addr (mem_req_addr)
  );

  assign rsp_unused = ^{mem_rsp_data[PTE_W-1:PA_W], mem_rsp_data[OFF_W-1:1],
                        root_base[OFF_W-1:0]};

  // next-state logic
  always_comb begin
    state_d = state_q;
    lvl_d   = lvl_q;
    base_d  = base_q;
    va_en   = 1'b0;
    base_en = 1'b0;
    lvl_en  = 1'b0;
    pa_en   = 1'b0;
    done_d  = 1'b0;
    fault_d = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d = ST_ISSUE;
          va_en   = 1'b1;
          base_en = 1'b1;
          base_d  = root_base[PA_W-1:OFF_W];
          lvl_en  = 1'b1;
          lvl_d   = '0;
        end
      end
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          if (!mem_rsp_data[0]) begin
            fault_d = 1'b1;
            state_d = ST_IDLE;
          end else if (lvl_q == LAST_LVL) begin
            done_d  = 1'b1;
            pa_en   = 1'b1;
            state_d = ST_IDLE;
          end else begin
            base_en = 1'b1;
            base_d  = mem_rsp_data[PA_W-1:OFF_W];
            lvl_en  = 1'b1;
            lvl_d   = lvl_q + LVL_W'(1);
            state_d = ST_ISSUE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign pa_d = {mem_rsp_data[PA_W-1:OFF_W], va_q[OFF_W-1:0]};

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      lvl_q   <= '0;
      va_q    <= '0;
      base_q  <= '0;
      pa_q    <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      fault_q <= fault_d;
      if (va_en)   va_q   <= req_vaddr;
      if (base_en) base_q <= base_d;
      if (lvl_en)  lvl_q  <= lvl_d;
      if (pa_en)   pa_q   <= pa_d;
    end
  end

  assign busy          = (state_q != ST_IDLE);
  assign mem_req_valid = (state_q == ST_ISSUE);
  assign done          = done_q;
  assign fault         = fault_q;
  assign paddr         = pa_q;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic busy,
  input logic mem_req_valid,
  input logic mem_rsp_valid,
  input logic done,
  input logic fault
);
  logic read_open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             read_open_q <= 1'b0;
    else if (mem_req_valid) read_open_q <= 1'b1;
    else if (mem_rsp_valid) read_open_q <= 1'b0;
  end

  // R5: read strobe lasts one cycle
  a_r5_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);

  // R5: no second read while one is still unanswered
  a_r5_one_open: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !read_open_q);

  // R10: outcomes are exclusive
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));

  // R8: walker is idle in the cycle it reports an outcome
  a_r8_idle_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |-> !busy);

  // R6 / R7: an outcome follows a memory response
  a_r6_end_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |-> $past(mem_rsp_valid));

  // R2: a walk only starts from a request
  a_r2_start_on_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  // R6: no read in the cycle a fault is reported
  a_r6_no_read_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !mem_req_valid);
endmodule

bind ptw_walker ptw_walker_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .busy          (busy),
  .mem_req_valid (mem_req_valid),
  .mem_rsp_valid (mem_rsp_valid),
  .done          (done),
  .fault         (fault)
);

// File: tb/ptw_walker_tb_top.sv
`timescale 1ns/1ps
module ptw_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [47:0] req_vaddr = '0;
  logic [51:0] root_base = '0;
  logic        busy, mem_req_valid, done, fault;
  logic [51:0] mem_req_addr, paddr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;

  always #10 clk = ~clk;

  ptw_walker dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .root_base(root_base), .busy(busy), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .fault(fault), .paddr(paddr)
  );

  int checks = 0;
  int fails  = 0;
  int reads  = 0;
  bit cmp_en = 1'b0;

  logic [63:0] mem [logic [51:0]];

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // behavioural reference model, advanced on each rising edge
  int          m_phase;   // 0 idle, 1 read to issue, 2 awaiting data
  int          m_lvl;
  logic [47:0] m_va;
  logic [39:0] m_base;
  logic [51:0] m_pa;
  bit          m_done, m_fault;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_lvl = 0; m_va = '0; m_base = '0; m_pa = '0;
      m_done = 0; m_fault = 0;
    end else begin
      m_done = 0; m_fault = 0;
      if (m_phase == 0) begin
        if (req_valid) begin
          m_va = req_vaddr; m_base = root_base[51:12]; m_lvl = 0; m_phase = 1;
        end
      end else if (m_phase == 1) begin
        m_phase = 2;
      end else if (mem_rsp_valid) begin
        if (!mem_rsp_data[0]) begin
          m_fault = 1; m_phase = 0;
        end else if (m_lvl == 3) begin
          m_done = 1; m_pa = {mem_rsp_data[51:12], m_va[11:0]}; m_phase = 0;
        end else begin
          m_base = mem_rsp_data[51:12]; m_lvl++; m_phase = 1;
        end
      end
    end
  end

  function automatic logic [51:0] model_addr();
    logic [51:0] ix;
    ix = 52'((m_va >> (39 - 9 * m_lvl)) & 48'h1FF);
    return {m_base, 12'h000} + (ix << 3);
  endfunction

  // per-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R8 busy vs model", 64'(busy), 64'(m_phase != 0));
      chk("R5 read strobe vs model", 64'(mem_req_valid), 64'(m_phase == 1));
      if (mem_req_valid) chk("R4 read address vs model", 64'(mem_req_addr), 64'(model_addr()));
      chk("R7 done vs model", 64'(done), 64'(m_done));
      chk("R6 fault vs model", 64'(fault), 64'(m_fault));
      chk("R7 paddr vs model", 64'(paddr), 64'(m_pa));
    end
  end

  // memory responder: latency rotates through 0..2 extra cycles
  bit          pend = 0;
  int          wait_cnt = 0;
  int          lat_sel = 0;
  logic [51:0] pend_addr = '0;

  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (pend) begin
      if (wait_cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem.exists(pend_addr) ? mem[pend_addr] : 64'h0;
        pend = 0;
      end else begin
        wait_cnt--;
      end
    end
    if (mem_req_valid && rst_n) begin
      pend = 1; pend_addr = mem_req_addr; wait_cnt = lat_sel;
      lat_sel = (lat_sel + 1) % 3; reads++;
    end
  end

  function automatic logic [51:0] ent_addr(input logic [39:0] b, input logic [47:0] va, input int lvl);
    logic [51:0] ix;
    ix = 52'((va >> (39 - 9 * lvl)) & 48'h1FF);
    return {b, 12'h000} + (ix << 3);
  endfunction

  // present entry with junk in the ignored bit ranges
  function automatic logic [63:0] pte(input logic [39:0] b);
    return {12'hA5C, b, 12'h023};
  endfunction

  task automatic map_page(input logic [51:0] root, input logic [47:0] va,
                          input logic [39:0] t1, input logic [39:0] t2,
                          input logic [39:0] t3, input logic [39:0] frm);
    mem[ent_addr(root[51:12], va, 0)] = pte(t1);
    mem[ent_addr(t1, va, 1)] = pte(t2);
    mem[ent_addr(t2, va, 2)] = pte(t3);
    mem[ent_addr(t3, va, 3)] = pte(frm);
  endtask

  task automatic do_walk(input logic [47:0] va, input logic [51:0] root, input bit exp_f,
                         input logic [51:0] exp_pa, input int exp_reads, input bit noise,
                         input string tag);
    int cyc;
    int rd_end;
    @(negedge clk);
    req_vaddr = va; root_base = root; req_valid = 1'b1; reads = 0;
    @(negedge clk);
    chk({tag, " R8 busy after accept"}, 64'(busy), 64'd1);
    if (noise) begin
      // R2: requests during a walk must be ignored
      req_vaddr = ~va; root_base = root ^ 52'h5_0000;
      for (int k = 0; k < 5; k++) @(negedge clk);
    end
    req_valid = 1'b0;
    cyc = 0;
    while (!(done || fault) && cyc < 300) begin
      @(negedge clk); cyc++;
    end
    chk({tag, " R10 not both"}, 64'(done && fault), 64'd0);
    chk({tag, " R6 fault outcome"}, 64'(fault), 64'(exp_f));
    chk({tag, " R7 done outcome"}, 64'(done), 64'(!exp_f));
    chk({tag, " R7 paddr"}, 64'(paddr), 64'(exp_pa));
    chk({tag, " R5 read count"}, 64'(reads), 64'(exp_reads));
    chk({tag, " R8 idle at end"}, 64'(busy), 64'd0);
    @(negedge clk);
    chk({tag, " R10 single pulse"}, 64'(done || fault), 64'd0);
    rd_end = reads;
    repeat (3) @(negedge clk);
    chk({tag, " R2 no stray walk"}, 64'(busy), 64'd0);
    chk({tag, " R2 no stray read"}, 64'(reads), 64'(rd_end));
  endtask

  localparam logic [51:0] ROOT_A = 52'h0_0000_0010_0000;
  localparam logic [51:0] ROOT_B = 52'h0_0000_0090_0ABC;

  initial begin
    logic [47:0] va1, va2, va3, vf;
    logic [51:0] last_pa;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 done", 64'(done), 64'd0);
    chk("R1 fault", 64'(fault), 64'd0);
    chk("R1 read strobe", 64'(mem_req_valid), 64'd0);
    chk("R1 paddr", 64'(paddr), 64'd0);
    cmp_en = 1'b1;

    // R3 R4 R7: full walk, mixed indices
    va1 = 48'h7F12_3456_789A;
    map_page(ROOT_A, va1, 40'h201, 40'h302, 40'h403, 40'hABCDE);
    do_walk(va1, ROOT_A, 0, {40'hABCDE, va1[11:0]}, 4, 0, "walk1");

    // R4: all-ones indices
    va2 = 48'hFFFF_FFFF_FFFF;
    map_page(ROOT_A, va2, 40'h211, 40'h312, 40'h413, 40'hF_FFFF_FFFE);
    do_walk(va2, ROOT_A, 0, {40'hF_FFFF_FFFE, va2[11:0]}, 4, 0, "walk2");

    // R2: requests held high during the walk are ignored
    va3 = 48'h0000_0000_1234;
    map_page(ROOT_A, va3, 40'h221, 40'h322, 40'h423, 40'h1_2345);
    do_walk(va3, ROOT_A, 0, {40'h1_2345, va3[11:0]}, 4, 1, "walk3");

    // R9: same address under another root, low root bits ignored (R3)
    map_page(ROOT_B, va1, 40'h901, 40'h902, 40'h903, 40'h7_7777);
    do_walk(va1, ROOT_B, 0, {40'h7_7777, va1[11:0]}, 4, 0, "root_b");
    do_walk(va1, ROOT_A, 0, {40'hABCDE, va1[11:0]}, 4, 0, "root_a_again");
    last_pa = {40'hABCDE, va1[11:0]};

    // R6: non-present entry at each level
    for (int l = 0; l < 4; l++) begin
      logic [39:0] tb4 [4];
      vf = 48'h1234_5678_9000 + 48'(l) * 48'h40_2010_0000;
      tb4[0] = ROOT_A[51:12]; tb4[1] = 40'h600 + 40'(l * 16);
      tb4[2] = 40'h601 + 40'(l * 16); tb4[3] = 40'h602 + 40'(l * 16);
      map_page(ROOT_A, vf, tb4[1], tb4[2], tb4[3], 40'h5_5555);
      mem[ent_addr(tb4[l], vf, l)] = 64'hFFFF_FFFF_FFFF_FFFE;
      do_walk(vf, ROOT_A, 1, last_pa, l + 1, 0, $sformatf("R6 fault_lvl%0d", l));
    end

    // R7: good walk right after a fault
    do_walk(va2, ROOT_A, 0, {40'hF_FFFF_FFFE, va2[11:0]}, 4, 1, "after_fault");

    cmp_en = 1'b0;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R8 watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule